// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block drives one power-enable line toward an external power-management chip, which switches the system supply on and off. A configuration word sets three things: a master enable that hands control of the line to the block, a per-pin enable for each external wake input, and a per-pin polarity for each of those inputs. When the master enable is set and a qualifying second-alarm event arrives from the calendar clock, the line drops and the system powers down. While the line is low, an enabled wake pin at its active level, or a first-alarm event with its interrupt enable set, raises it again.

A second-alarm event counts only when its interrupt enable is set and its sticky status flag was clear beforehand. Software has to clear the flag before it arms a new power-off. Configuration writes take effect only while an external key gate reports the register unlocked and the write targets the block's own address. Each wake pin is asynchronous and passes through a synchronizer before its polarity is applied.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset `pwr_en` is 1, `alm2_stat` is 0, and `cfg_rdata` reads 0x000000F0, meaning every pin is disabled and every pin is active-low.
- R2: A write changes the configuration only when `cfg_we`, `cfg_unlocked` and `cfg_addr` == 0x98 are all true. The written word appears on `cfg_rdata` on the next cycle. Only bit 16 (master enable), bits 3:0 (pin enables) and bits 7:4 (pin polarities) are kept, and every other bit reads 0.
- R3: While bit 16 is 0, `pwr_en` is held at 1 and second-alarm events do not change it.
- R4: With bit 16 set, a second-alarm pulse that arrives while `alm2_irq_en` is 1 and `alm2_stat` is 0 drives `pwr_en` to 0 at the next clock edge.
- R5: A second-alarm pulse has no effect on `pwr_en` if `alm2_irq_en` is 0 or if `alm2_stat` is already 1.
- R6: Every second-alarm pulse sets `alm2_stat` at the next edge, whatever the configuration. `alm2_stat_clr` clears it, and a pulse in the same cycle as a clear wins.
- R7: While the output is off, a pin whose enable bit is 1 and whose level is active raises `pwr_en` on the third clock edge after the pin changes. The pin is active when low if its polarity bit (bit 4+i) is 1, and active when high if that bit is 0.
- R8: A pin whose enable bit is 0 never raises `pwr_en`, whatever its level.
- R9: While the output is off, a first-alarm pulse with `alm1_irq_en` at 1 raises `pwr_en` at the next edge. With `alm1_irq_en` at 0 the pulse is ignored.
- R10: Clearing bit 16 while the output is off raises `pwr_en` one edge after the configuration write lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unlocked | input | 1 | Key gate state, 1 = writes allowed |
| cfg_addr | input | 8 | Write address, byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| alm2_pulse | input | 1 | Second-alarm match event, one cycle |
| alm2_irq_en | input | 1 | Second-alarm interrupt enable |
| alm2_stat_clr | input | 1 | Clears the second-alarm status flag |
| alm2_stat | output | 1 | Sticky second-alarm status flag |
| alm1_pulse | input | 1 | First-alarm match event, one cycle |
| alm1_irq_en | input | 1 | First-alarm interrupt enable |
| wake_pins | input | 4 | Asynchronous external wake inputs |
| pwr_en | output | 1 | Power-enable line, 1 = supply on |

## Verification
The assertions check four things on every cycle: the line stays high whenever the master enable is clear, it falls exactly one edge after an honoured off request and at no other time, it rises only after a wake or a dropped master enable, and every second-alarm pulse leaves the status flag set. Other properties need a particular sequence of stimulus, and only the bench scenarios can show them: the exact three-edge latency through the synchronizer, the per-pin polarity and enable selection, the write protection and address decode, and the rule that a status flag left set blocks the next power-off.

// File: rtl/pmic_pwr_pkg.sv
package pmic_pwr_pkg;
  localparam int CFG_W        = 32;
  localparam int CTL_EN_BIT   = 16;
  localparam int POL_BASE     = 4;

  typedef enum logic {
    PWR_OFF = 1'b0,
    PWR_ON  = 1'b1
  } pwr_state_e;

  // Level seen on a synced pin counts as active: pol=1 means active-low.
  function automatic logic pin_is_active(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction
endpackage

// File: rtl/pmic_cfg_reg.sv
module pmic_cfg_reg #(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h98,
  parameter int          NPIN     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic                            unlocked,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [pmic_pwr_pkg::CFG_W-1:0]  wdata,
  output logic [pmic_pwr_pkg::CFG_W-1:0]  rdata,
  output logic                            ctl_en,
  output logic [NPIN-1:0]                 pin_en,
  output logic [NPIN-1:0]                 pin_pol
);
  import pmic_pwr_pkg::*;

  localparam logic [CFG_W-1:0] EN_MASK  = CFG_W'((1 << NPIN) - 1);
  localparam logic [CFG_W-1:0] POL_MASK = EN_MASK << POL_BASE;
  localparam logic [CFG_W-1:0] CTL_MASK = CFG_W'(1) << CTL_EN_BIT;
  localparam logic [CFG_W-1:0] KEEP     = EN_MASK | POL_MASK | CTL_MASK;
  localparam logic [CFG_W-1:0] RST_VAL  = POL_MASK;

  logic [CFG_W-1:0] cfg_q;
  logic             wr_hit;

  assign wr_hit = we && unlocked && (addr == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= RST_VAL;
    else if (wr_hit) cfg_q <= wdata & KEEP;
  end

  assign rdata   = cfg_q;
  assign ctl_en  = cfg_q[CTL_EN_BIT];
  assign pin_en  = cfg_q[NPIN-1:0];
  assign pin_pol = cfg_q[POL_BASE +: NPIN];

  // R2
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlocked) |=> $stable(cfg_q));
endmodule

// File: rtl/pmic_wake_sync.sv
module pmic_wake_sync #(
  parameter int NPIN   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_async,
  input  logic [NPIN-1:0] pin_en,
  input  logic [NPIN-1:0] pin_pol,
  output logic [NPIN-1:0] pin_active,
  output logic            wake_hit
);
  import pmic_pwr_pkg::*;

  logic [NPIN-1:0] synced;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], pins_async[i]};
    end
    assign synced[i]     = chain[STAGES-1];
    assign pin_active[i] = pin_is_active(synced[i], pin_pol[i]);
  end

  assign wake_hit = |(pin_active & pin_en);
endmodule

// File: rtl/pmic_pwr_fsm.sv
module pmic_pwr_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_en,
  input  logic off_req,
  input  logic wake_req,
  output logic pwr_en
);
  import pmic_pwr_pkg::*;

  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!ctl_en)                            st_d = PWR_ON;
    else if (st_q == PWR_ON && off_req)     st_d = PWR_OFF;
    else if (st_q == PWR_OFF && wake_req)   st_d = PWR_ON;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PWR_ON;
    else        st_q <= st_d;
  end

  assign pwr_en = (st_q == PWR_ON);

  // R3
  held_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> pwr_en);
  // R4
  off_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && ctl_en && off_req) |=> !pwr_en);
  // R5
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(off_req && ctl_en));
  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(wake_req || !ctl_en));
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl #(
  parameter int         NPIN       = 4,
  parameter int         SYNC_DEPTH = 2,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_ADDR   = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_unlocked,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              alm2_pulse,
  input  logic              alm2_irq_en,
  input  logic              alm2_stat_clr,
  output logic              alm2_stat,
  input  logic              alm1_pulse,
  input  logic              alm1_irq_en,
  input  logic [NPIN-1:0]   wake_pins,
  output logic              pwr_en
);
  logic            ctl_en;
  logic [NPIN-1:0] pin_en, pin_pol, pin_active;
  logic            pin_wake, alm1_wake, wake_req, off_req;
  logic            stat_q;

  pmic_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .NPIN(NPIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .unlocked(cfg_unlocked),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .ctl_en(ctl_en), .pin_en(pin_en), .pin_pol(pin_pol)
  );

  pmic_wake_sync #(.NPIN(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_async(wake_pins), .pin_en(pin_en),
    .pin_pol(pin_pol), .pin_active(pin_active), .wake_hit(pin_wake)
  );

  // Sticky second-alarm status: a new event beats a clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             stat_q <= 1'b0;
    else if (alm2_pulse)    stat_q <= 1'b1;
    else if (alm2_stat_clr) stat_q <= 1'b0;
  end
  assign alm2_stat = stat_q;

  assign off_req   = alm2_pulse && alm2_irq_en && !stat_q;
  assign alm1_wake = alm1_pulse && alm1_irq_en;
  assign wake_req  = pin_wake || alm1_wake;

  pmic_pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .off_req(off_req),
    .wake_req(wake_req), .pwr_en(pwr_en)
  );

  // R6
  stat_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm2_pulse |=> alm2_stat);
  // R8
  disabled_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_wake |-> |(pin_active & pin_en));
endmodule

// File: tb/pmic_pwr_ctrl_tb.sv
module pmic_pwr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_unlocked = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        alm2_pulse = 1'b0, alm2_irq_en = 1'b0, alm2_stat_clr = 1'b0;
  logic        alm2_stat;
  logic        alm1_pulse = 1'b0, alm1_irq_en = 1'b0;
  logic [3:0]  wake_pins = 4'hF;
  logic        pwr_en;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pmic_pwr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unlocked(cfg_unlocked),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .alm2_pulse(alm2_pulse), .alm2_irq_en(alm2_irq_en),
    .alm2_stat_clr(alm2_stat_clr), .alm2_stat(alm2_stat),
    .alm1_pulse(alm1_pulse), .alm1_irq_en(alm1_irq_en),
    .wake_pins(wake_pins), .pwr_en(pwr_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic unl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_unlocked = unl;
    @(negedge clk);
    cfg_we = 1'b0; cfg_unlocked = 1'b0;
  endtask

  task automatic pulse2();
    @(negedge clk); alm2_pulse = 1'b1;
    @(negedge clk); alm2_pulse = 1'b0;
  endtask

  task automatic clr_stat();
    @(negedge clk); alm2_stat_clr = 1'b1;
    @(negedge clk); alm2_stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pwr_en", 32'(pwr_en), 32'd1);
    check("R1 stat", 32'(alm2_stat), 32'd0);
    check("R1 cfg", cfg_rdata, 32'h0000_00F0);
  endtask

  task automatic t_writes();
    wr(8'h98, 32'hFFFF_FFFF, 1'b0);
    check("R2 locked", cfg_rdata, 32'h0000_00F0);
    wr(8'h94, 32'hFFFF_FFFF, 1'b1);
    check("R2 wrong addr", cfg_rdata, 32'h0000_00F0);
    wr(8'h98, 32'hFFFF_FFFF, 1'b1);
    check("R2 kept bits", cfg_rdata, 32'h0001_00FF);
  endtask

  task automatic t_ctl_off();
    wr(8'h98, 32'h0000_00F1, 1'b1);
    alm2_irq_en = 1'b1;
    pulse2();
    check("R3 held on", 32'(pwr_en), 32'd1);
    check("R6 stat set", 32'(alm2_stat), 32'd1);
    clr_stat();
    check("R6 stat clr", 32'(alm2_stat), 32'd0);
    @(negedge clk); alm2_pulse = 1'b1; alm2_stat_clr = 1'b1;
    @(negedge clk); alm2_pulse = 1'b0; alm2_stat_clr = 1'b0;
    check("R6 set beats clr", 32'(alm2_stat), 32'd1);
    clr_stat();
  endtask

  task automatic t_off_rules();
    wr(8'h98, 32'h0001_00F1, 1'b1);
    alm2_irq_en = 1'b0;
    pulse2();
    check("R5 irq off", 32'(pwr_en), 32'd1);
    alm2_irq_en = 1'b1;
    pulse2();
    check("R5 stat set", 32'(pwr_en), 32'd1);
    clr_stat();
    pulse2();
    check("R4 off", 32'(pwr_en), 32'd0);
  endtask

  task automatic t_pin_wake();
    @(negedge clk); wake_pins = 4'b1101;
    repeat (4) @(negedge clk);
    check("R8 disabled pin", 32'(pwr_en), 32'd0);
    wake_pins = 4'b1100;
    @(negedge clk); @(negedge clk);
    check("R7 not yet", 32'(pwr_en), 32'd0);
    @(negedge clk);
    check("R7 low wake", 32'(pwr_en), 32'd1);
    wake_pins = 4'b1111;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_pol_high();
    wr(8'h98, 32'h0001_00B4, 1'b1);
    @(negedge clk); wake_pins = 4'b1011;
    repeat (3) @(negedge clk);
    clr_stat();
    pulse2();
    check("R4 off again", 32'(pwr_en), 32'd0);
    wake_pins = 4'b1111;
    @(negedge clk); @(negedge clk);
    check("R7 high not yet", 32'(pwr_en), 32'd0);
    @(negedge clk);
    check("R7 high wake", 32'(pwr_en), 32'd1);
    wake_pins = 4'b1011;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_alm1();
    clr_stat();
    pulse2();
    check("R4 off alm1", 32'(pwr_en), 32'd0);
    alm1_irq_en = 1'b0;
    @(negedge clk); alm1_pulse = 1'b1;
    @(negedge clk); alm1_pulse = 1'b0;
    check("R9 ignored", 32'(pwr_en), 32'd0);
    alm1_irq_en = 1'b1;
    @(negedge clk); alm1_pulse = 1'b1;
    @(negedge clk); alm1_pulse = 1'b0;
    check("R9 wake", 32'(pwr_en), 32'd1);
  endtask

  task automatic t_release();
    clr_stat();
    pulse2();
    check("R4 off rel", 32'(pwr_en), 32'd0);
    wr(8'h98, 32'h0000_00B4, 1'b1);
    check("R10 one edge", 32'(pwr_en), 32'd0);
    @(negedge clk);
    check("R10 on", 32'(pwr_en), 32'd1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_writes();
    t_ctl_off();
    t_off_rules();
    t_pin_wake();
    t_pol_high();
    t_alm1();
    t_release();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule